// File: doc/BRIEF.md
# Binary/BCD Clock-Calendar Counter

This block keeps wall-clock time and calendar date. It holds seconds, minutes, hours, day of week, date, month and a two-digit year. A once-per-second enable advances it. That enable is produced elsewhere from a 32.768 kHz time base. Every accepted second ripples through the whole carry chain in a single clock cycle. In that same cycle the block raises a one-cycle completion strobe, so a host knows the value set it reads next is coherent.

The count is held internally as a binary, 24-hour value. Two mode inputs choose how the host sees and writes it: binary or BCD, and 24-hour or 12-hour with an AM/PM flag. Both the read path and the load path are converted to match. A daylight-saving enable adds two changeovers. The first is a spring-forward hour skip on the first Sunday of April. The second is a single repeat of the 1 a.m. hour on the last Sunday of October.

To set the time, the host raises the halt input. This freezes the chain. While halt is high, the host presents all seven fields on the load ports and pulses the load strobe.

Top module: `rtc_calendar_core`

## Requirements
- R1: An accepted tick adds one to the seconds. Seconds 59 wrap to 0 and carry into the minutes. Minutes 59 wrap to 0 and carry into the hours. Hour 23 wraps to 0 and carries into the day fields.
- R2: Day of week runs from 1 to 7. On the midnight carry, 7 wraps to 1 and any other value adds one.
- R3: At the midnight carry the date wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days, and the other months except February have 31. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0.
- R4: February has 29 days when the year is divisible by four (low two binary bits zero) and 28 days otherwise.
- R5: With bin_mode=1 every field reads and loads as plain binary. With bin_mode=0 every field is BCD, with tens in bits 7:4 and ones in bits 3:0. Changing the mode changes only the representation, never the stored time.
- R6: With h24_mode=0 the hour field carries PM in bit 7 and the hour value (12, then 1 to 11) in bits 6:0. Midnight reads as 12 with bit 7 clear, and noon reads as 12 with bit 7 set. With h24_mode=1 the hour runs from 0 to 23.
- R7: With dst_en=1, a tick at 01:59:59 on a Sunday (day of week 1) in April with date 1 to 7 moves the time to 03:00:00. With dst_en=0, or on any other day, the hour advances normally.
- R8: With dst_en=1, a tick at 01:59:59 on a Sunday in October with date 25 or later moves the time to 01:00:00, once. The repeated hour then ends at 02:00:00. A load re-arms the repeat.
- R9: upd_done is high for exactly the one cycle that follows each clock edge at which sec_tick=1 and halt=0. The new time is visible in that same cycle.
- R10: While halt=1, ticks are ignored and upd_done stays low. The load ports are taken only on an edge where halt=1 and ld_en=1. ld_en with halt=0 has no effect.
- R11: Reset gives 00:00:00, day of week 1, date 1, month 1, year 0 and upd_done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle once-per-second advance enable |
| halt | input | 1 | Freeze counting and allow loads |
| bin_mode | input | 1 | 1 = binary representation, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour hour field, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enable daylight-saving changeovers |
| ld_en | input | 1 | Load strobe, honoured only while halt is high |
| ld_sec | input | 8 | Seconds to load, host format |
| ld_min | input | 8 | Minutes to load, host format |
| ld_hour | input | 8 | Hour to load, host format |
| ld_dow | input | 8 | Day of week to load, 1 to 7 |
| ld_date | input | 8 | Date to load, host format |
| ld_month | input | 8 | Month to load, host format |
| ld_year | input | 8 | Year to load, host format |
| cur_sec | output | 8 | Current seconds |
| cur_min | output | 8 | Current minutes |
| cur_hour | output | 8 | Current hour |
| cur_dow | output | 8 | Current day of week |
| cur_date | output | 8 | Current date |
| cur_month | output | 8 | Current month |
| cur_year | output | 8 | Current year |
| upd_done | output | 1 | One-cycle strobe after each accepted tick |

## Verification
Two pairs of functions can fall in the same clock cycle.

The first pair is a host freeze and a tick. The bench holds halt high while pulsing sec_tick, and separately pulses ld_en with halt low. It then judges the seven outputs and the absence of upd_done against the values loaded before.

The second pair is a daylight-saving changeover and the ordinary minute-to-hour carry. Vectors load 01:59:59 on Sundays in April and October, with the enable on and off and on a non-Sunday, and check the hour after one tick. A directed run then ticks through the full repeated hour to confirm the October shift happens only once.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int CAL_W  = 8;
    localparam int NFIELD = 7;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YR   = 6;

    localparam logic [CAL_W-1:0] SEC_LAST        = CAL_W'(59);
    localparam logic [CAL_W-1:0] MIN_LAST        = CAL_W'(59);
    localparam logic [CAL_W-1:0] HR_LAST         = CAL_W'(23);
    localparam logic [CAL_W-1:0] DOW_FIRST       = CAL_W'(1);
    localparam logic [CAL_W-1:0] DOW_LAST        = CAL_W'(7);
    localparam logic [CAL_W-1:0] DAY_FIRST       = CAL_W'(1);
    localparam logic [CAL_W-1:0] MON_FIRST       = CAL_W'(1);
    localparam logic [CAL_W-1:0] MON_LAST        = CAL_W'(12);
    localparam logic [CAL_W-1:0] YR_LAST         = CAL_W'(99);
    localparam logic [CAL_W-1:0] DST_HR          = CAL_W'(1);
    localparam logic [CAL_W-1:0] DST_SKIP_HR     = CAL_W'(3);
    localparam logic [CAL_W-1:0] SPRING_MON      = CAL_W'(4);
    localparam logic [CAL_W-1:0] FALL_MON        = CAL_W'(10);
    localparam logic [CAL_W-1:0] WEEK1_LAST      = CAL_W'(7);
    localparam logic [CAL_W-1:0] LAST_WEEK_FIRST = CAL_W'(25);

    typedef struct packed {
        logic [CAL_W-1:0] sec;
        logic [CAL_W-1:0] min;
        logic [CAL_W-1:0] hr;
        logic [CAL_W-1:0] dow;
        logic [CAL_W-1:0] date;
        logic [CAL_W-1:0] mon;
        logic [CAL_W-1:0] yr;
        logic             fell;
        logic             upd;
    } cal_state_t;

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
    parameter int W = 8
) (
    input  logic [W-1:0] month,
    input  logic [1:0]   yr_lo,
    output logic [W-1:0] last_day
);
    localparam logic [W-1:0] D28 = W'(28);
    localparam logic [W-1:0] D29 = W'(29);
    localparam logic [W-1:0] D30 = W'(30);
    localparam logic [W-1:0] D31 = W'(31);

    logic leap_yr;
    assign leap_yr = (yr_lo == 2'b00);

    always_comb begin
        case (month)
            W'(2):                      last_day = leap_yr ? D29 : D28;
            W'(4), W'(6), W'(9), W'(11): last_day = D30;
            default:                    last_day = D31;
        endcase
    end
endmodule

// File: rtl/rtc_field_dec.sv
module rtc_field_dec #(
    parameter int W       = 8,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [W-1:0] code,
    input  logic         bin_mode,
    input  logic         h24_mode,
    output logic [W-1:0] val
);
    localparam logic [W-1:0] TEN    = W'(10);
    localparam logic [W-1:0] TWELVE = W'(12);
    localparam logic [W-1:0] NIBBLE = W'(15);

    logic [W-1:0] raw, hi, lo, mag;
    logic         pm;

    always_comb begin
        raw = code;
        pm  = 1'b0;
        if (IS_HOUR && !h24_mode) begin
            pm         = code[W-1];
            raw[W-1]   = 1'b0;
        end
        hi  = raw >> 4;
        lo  = raw & NIBBLE;
        mag = bin_mode ? raw : (hi * TEN + lo);
        val = mag;
        if (IS_HOUR && !h24_mode) begin
            if (mag == TWELVE) val = '0;
            if (pm)            val = val + TWELVE;
        end
    end
endmodule

// File: rtl/rtc_field_enc.sv
module rtc_field_enc #(
    parameter int W       = 8,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [W-1:0] val,
    input  logic         bin_mode,
    input  logic         h24_mode,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] TEN    = W'(10);
    localparam logic [W-1:0] TWELVE = W'(12);

    logic [W-1:0] mag, tens, ones;
    logic         pm;

    always_comb begin
        pm  = 1'b0;
        mag = val;
        if (IS_HOUR && !h24_mode) begin
            pm = (val >= TWELVE);
            if (val == '0)         mag = TWELVE;
            else if (val > TWELVE) mag = val - TWELVE;
        end
        tens = mag / TEN;
        ones = mag % TEN;
        code = bin_mode ? mag : ((tens << 4) | ones);
        if (pm) code[W-1] = 1'b1;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             halt,
    input  logic             bin_mode,
    input  logic             h24_mode,
    input  logic             dst_en,
    input  logic             ld_en,
    input  logic [CAL_W-1:0] ld_sec,
    input  logic [CAL_W-1:0] ld_min,
    input  logic [CAL_W-1:0] ld_hour,
    input  logic [CAL_W-1:0] ld_dow,
    input  logic [CAL_W-1:0] ld_date,
    input  logic [CAL_W-1:0] ld_month,
    input  logic [CAL_W-1:0] ld_year,
    output logic [CAL_W-1:0] cur_sec,
    output logic [CAL_W-1:0] cur_min,
    output logic [CAL_W-1:0] cur_hour,
    output logic [CAL_W-1:0] cur_dow,
    output logic [CAL_W-1:0] cur_date,
    output logic [CAL_W-1:0] cur_month,
    output logic [CAL_W-1:0] cur_year,
    output logic             upd_done
);
    localparam logic [CAL_W-1:0] ONE = CAL_W'(1);
    localparam cal_state_t CAL_RST = '{
        sec: '0, min: '0, hr: '0, dow: DOW_FIRST, date: DAY_FIRST,
        mon: MON_FIRST, yr: '0, fell: 1'b0, upd: 1'b0};

    cal_state_t s_q, s_d;

    logic [NFIELD-1:0][CAL_W-1:0] ld_vec, dec_vec, cur_vec, enc_vec;
    logic [CAL_W-1:0]             last_day;

    assign ld_vec[F_SEC]  = ld_sec;
    assign ld_vec[F_MIN]  = ld_min;
    assign ld_vec[F_HR]   = ld_hour;
    assign ld_vec[F_DOW]  = ld_dow;
    assign ld_vec[F_DATE] = ld_date;
    assign ld_vec[F_MON]  = ld_month;
    assign ld_vec[F_YR]   = ld_year;

    assign cur_vec[F_SEC]  = s_q.sec;
    assign cur_vec[F_MIN]  = s_q.min;
    assign cur_vec[F_HR]   = s_q.hr;
    assign cur_vec[F_DOW]  = s_q.dow;
    assign cur_vec[F_DATE] = s_q.date;
    assign cur_vec[F_MON]  = s_q.mon;
    assign cur_vec[F_YR]   = s_q.yr;

    // host-format conversion on the load and read paths, one pair per field
    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
        rtc_field_dec #(.W(CAL_W), .IS_HOUR(gi == F_HR)) u_dec (
            .code     (ld_vec[gi]),
            .bin_mode (bin_mode),
            .h24_mode (h24_mode),
            .val      (dec_vec[gi])
        );
        rtc_field_enc #(.W(CAL_W), .IS_HOUR(gi == F_HR)) u_enc (
            .val      (cur_vec[gi]),
            .bin_mode (bin_mode),
            .h24_mode (h24_mode),
            .code     (enc_vec[gi])
        );
    end

    rtc_month_len #(.W(CAL_W)) u_mlen (
        .month    (s_q.mon),
        .yr_lo    (s_q.yr[1:0]),
        .last_day (last_day)
    );

    logic tick_ok, sec_end, min_end, hr_end, day_end, mon_end;
    logic hour_carry, day_carry, dst_zone, spring_fwd, fall_back;

    assign tick_ok    = sec_tick & ~halt;
    assign sec_end    = (s_q.sec  >= SEC_LAST);
    assign min_end    = (s_q.min  >= MIN_LAST);
    assign hr_end     = (s_q.hr   >= HR_LAST);
    assign day_end    = (s_q.date >= last_day);
    assign mon_end    = (s_q.mon  >= MON_LAST);
    assign hour_carry = tick_ok & sec_end & min_end;
    assign day_carry  = hour_carry & hr_end;
    assign dst_zone   = dst_en & (s_q.hr == DST_HR) & (s_q.dow == DOW_FIRST);
    assign spring_fwd = dst_zone & (s_q.mon == SPRING_MON) & (s_q.date <= WEEK1_LAST);
    assign fall_back  = dst_zone & (s_q.mon == FALL_MON) & (s_q.date >= LAST_WEEK_FIRST)
                      & ~s_q.fell;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (halt) begin
            if (ld_en) begin
                s_d.sec  = dec_vec[F_SEC];
                s_d.min  = dec_vec[F_MIN];
                s_d.hr   = dec_vec[F_HR];
                s_d.dow  = dec_vec[F_DOW];
                s_d.date = dec_vec[F_DATE];
                s_d.mon  = dec_vec[F_MON];
                s_d.yr   = dec_vec[F_YR];
                s_d.fell = 1'b0;
            end
        end else if (sec_tick) begin
            s_d.upd = 1'b1;
            s_d.sec = sec_end ? '0 : s_q.sec + ONE;
            if (sec_end) s_d.min = min_end ? '0 : s_q.min + ONE;
            if (hour_carry) begin
                if (spring_fwd) begin
                    s_d.hr = DST_SKIP_HR;
                end else if (fall_back) begin
                    s_d.hr   = DST_HR;
                    s_d.fell = 1'b1;
                end else begin
                    s_d.fell = 1'b0;
                    s_d.hr   = hr_end ? '0 : s_q.hr + ONE;
                end
            end
            if (day_carry) begin
                s_d.dow  = (s_q.dow >= DOW_LAST) ? DOW_FIRST : s_q.dow + ONE;
                s_d.date = day_end ? DAY_FIRST : s_q.date + ONE;
                if (day_end) begin
                    s_d.mon = mon_end ? MON_FIRST : s_q.mon + ONE;
                    if (mon_end) s_d.yr = (s_q.yr >= YR_LAST) ? '0 : s_q.yr + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CAL_RST;
        else        s_q <= s_d;
    end

    assign cur_sec   = enc_vec[F_SEC];
    assign cur_min   = enc_vec[F_MIN];
    assign cur_hour  = enc_vec[F_HR];
    assign cur_dow   = enc_vec[F_DOW];
    assign cur_date  = enc_vec[F_DATE];
    assign cur_month = enc_vec[F_MON];
    assign cur_year  = enc_vec[F_YR];
    assign upd_done  = s_q.upd;

    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && s_q.sec == SEC_LAST) |=> (s_q.sec == '0 && s_q.min != $past(s_q.min))); // R1
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && s_q.dow == DOW_LAST) |=> (s_q.dow == DOW_FIRST)); // R2
    AST_LEAP_DAY: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && s_q.mon == CAL_W'(2) && s_q.date == CAL_W'(28) && s_q.yr[1:0] == 2'b00)
        |=> (s_q.date == CAL_W'(29))); // R4
    AST_SPRING_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_carry && dst_en && s_q.hr == DST_HR && s_q.dow == DOW_FIRST
         && s_q.mon == SPRING_MON && s_q.date <= WEEK1_LAST) |=> (s_q.hr == DST_SKIP_HR)); // R7
    AST_UPD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !$stable(s_q.sec)); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ld_en) |=> ($stable(s_q.sec) && $stable(s_q.hr) && $stable(s_q.date)
                              && !upd_done)); // R10
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, halt = 1'b0, bin_mode = 1'b1, h24_mode = 1'b1, dst_en = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_dow, cur_date, cur_month, cur_year;
    logic       upd_done;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .halt(halt),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .dst_en(dst_en), .ld_en(ld_en),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
        .cur_date(cur_date), .cur_month(cur_month), .cur_year(cur_year),
        .upd_done(upd_done)
    );

    // {bin, h24, dst, load sec,min,hr,dow,date,mon,yr, expected sec,min,hr,dow,date,mon,yr}
    localparam int NV = 14;
    localparam logic [114:0] VEC [NV] = '{
        // R1 full carry in binary 24h
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd23,8'd3,8'd15,8'd6,8'd24,  8'd0,8'd0,8'd0,8'd4,8'd16,8'd6,8'd24},
        // R5 BCD minute-to-hour carry
        {1'b0,1'b1,1'b0, 8'h59,8'h59,8'h09,8'h02,8'h10,8'h03,8'h21, 8'h00,8'h00,8'h10,8'h02,8'h10,8'h03,8'h21},
        // R3 30-day month, R2 day of week 7 -> 1
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd23,8'd7,8'd30,8'd4,8'd5,   8'd0,8'd0,8'd0,8'd1,8'd1,8'd5,8'd5},
        // R3 year 99 -> 00 in BCD
        {1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h05,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h00},
        // R4 Feb 28 leap year
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd23,8'd1,8'd28,8'd2,8'd24,  8'd0,8'd0,8'd0,8'd2,8'd29,8'd2,8'd24},
        // R4 Feb 28 common year
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd23,8'd1,8'd28,8'd2,8'd23,  8'd0,8'd0,8'd0,8'd2,8'd1,8'd3,8'd23},
        // R4 Feb 29 leap year
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd23,8'd1,8'd29,8'd2,8'd24,  8'd0,8'd0,8'd0,8'd2,8'd1,8'd3,8'd24},
        // R6 11 PM -> 12 AM, BCD
        {1'b0,1'b0,1'b0, 8'h59,8'h59,8'h91,8'h03,8'h10,8'h05,8'h30, 8'h00,8'h00,8'h12,8'h04,8'h11,8'h05,8'h30},
        // R6 11 AM -> 12 PM, binary
        {1'b1,1'b0,1'b0, 8'd59,8'd59,8'd11,8'd3,8'd10,8'd5,8'd30,  8'd0,8'd0,8'h8C,8'd3,8'd10,8'd5,8'd30},
        // R6 12 PM -> 1 PM, BCD
        {1'b0,1'b0,1'b0, 8'h59,8'h59,8'h92,8'h03,8'h10,8'h05,8'h30, 8'h00,8'h00,8'h81,8'h03,8'h10,8'h05,8'h30},
        // R7 spring skip
        {1'b1,1'b1,1'b1, 8'd59,8'd59,8'd1,8'd1,8'd3,8'd4,8'd24,    8'd0,8'd0,8'd3,8'd1,8'd3,8'd4,8'd24},
        // R7 disabled: no skip
        {1'b1,1'b1,1'b0, 8'd59,8'd59,8'd1,8'd1,8'd3,8'd4,8'd24,    8'd0,8'd0,8'd2,8'd1,8'd3,8'd4,8'd24},
        // R8 fall repeat
        {1'b1,1'b1,1'b1, 8'd59,8'd59,8'd1,8'd1,8'd27,8'd10,8'd24,  8'd0,8'd0,8'd1,8'd1,8'd27,8'd10,8'd24},
        // R7 not a Sunday: no skip
        {1'b1,1'b1,1'b1, 8'd59,8'd59,8'd1,8'd2,8'd3,8'd4,8'd24,    8'd0,8'd0,8'd2,8'd2,8'd3,8'd4,8'd24}
    };
    localparam int VTAG [NV] = '{1, 5, 3, 3, 4, 4, 4, 6, 6, 6, 7, 7, 8, 7};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] s, m, h, dw, dt, mo, y);
        @(negedge clk);
        halt = 1'b1; ld_en = 1'b1;
        ld_sec = s; ld_min = m; ld_hour = h; ld_dow = dw;
        ld_date = dt; ld_month = mo; ld_year = y;
        @(negedge clk);
        ld_en = 1'b0; halt = 1'b0;
    endtask

    task automatic do_tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic chk_all(input string tag, input logic [55:0] e);
        chk({tag, " sec"},   cur_sec,   e[55:48]);
        chk({tag, " min"},   cur_min,   e[47:40]);
        chk({tag, " hour"},  cur_hour,  e[39:32]);
        chk({tag, " dow"},   cur_dow,   e[31:24]);
        chk({tag, " date"},  cur_date,  e[23:16]);
        chk({tag, " month"}, cur_month, e[15:8]);
        chk({tag, " year"},  cur_year,  e[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_all("R11 reset", {8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0});
        chk("R11 upd", {7'd0, upd_done}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            bin_mode = VEC[i][114];
            h24_mode = VEC[i][113];
            dst_en   = VEC[i][112];
            do_load(VEC[i][111:104], VEC[i][103:96], VEC[i][95:88], VEC[i][87:80],
                    VEC[i][79:72], VEC[i][71:64], VEC[i][63:56]);
            do_tick();
            chk_all($sformatf("R%0d vec%0d", VTAG[i], i), VEC[i][55:0]);
            chk($sformatf("R9 upd vec%0d", i), {7'd0, upd_done}, 8'd1);
        end

        // R9 strobe lasts one cycle
        @(negedge clk);
        chk("R9 upd falls", {7'd0, upd_done}, 8'd0);

        // R10 tick during halt is dropped
        bin_mode = 1'b1; h24_mode = 1'b1; dst_en = 1'b0;
        do_load(8'd30, 8'd45, 8'd13, 8'd2, 8'd9, 8'd7, 8'd22);
        halt = 1'b1;
        do_tick();
        chk("R10 halt sec", cur_sec, 8'd30);
        chk("R10 halt upd", {7'd0, upd_done}, 8'd0);
        halt = 1'b0;
        // R10 load strobe without halt is ignored
        ld_sec = 8'd5; ld_hour = 8'd4; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        chk("R10 no-halt load sec", cur_sec, 8'd30);
        chk("R10 no-halt load hour", cur_hour, 8'd13);

        // R5 representation switch leaves stored time intact
        bin_mode = 1'b0;
        #1;
        chk("R5 bcd sec", cur_sec, 8'h30);
        chk("R5 bcd min", cur_min, 8'h45);
        chk("R5 bcd hour", cur_hour, 8'h13);
        h24_mode = 1'b0;
        #1;
        chk("R6 bcd 12h hour", cur_hour, 8'h81);
        bin_mode = 1'b1;
        #1;
        chk("R6 bin 12h hour", cur_hour, 8'h81);
        h24_mode = 1'b1;

        // R8 repeated hour happens once
        dst_en = 1'b1;
        do_load(8'd59, 8'd59, 8'd1, 8'd1, 8'd27, 8'd10, 8'd24);
        do_tick();
        chk("R8 fall first", cur_hour, 8'd1);
        for (int k = 0; k < 3599; k++) do_tick();
        chk("R8 repeat end sec", cur_sec, 8'd59);
        chk("R8 repeat end hour", cur_hour, 8'd1);
        do_tick();
        chk("R8 second pass hour", cur_hour, 8'd2);
        chk("R8 second pass min", cur_min, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule